// File: doc/BRIEF.md
# Software-Managed Address Translation Unit

This block turns a virtual byte address into a physical byte address for a small paged machine with 128-byte pages and 32 physical pages. It has two modes, picked by the `use_tlb` input. In associative mode it searches four entries that kernel software loads. In linear mode it indexes an eight-entry page table by virtual page number. That lookup is bounded by a software-supplied table size.

Each request carries an address, a size code and a write flag. One cycle later the unit returns a registered response with a valid strobe. The response holds either the physical address or an exception code. When an exception is raised, the failing virtual address is captured in a register that software can read. On a successful access, the entry that was used gets its referenced bit set, and also its dirty bit if the access was a write.

Software loads entries through a write port and inspects any entry through a combinational read port. Filling entries after a miss, moving memory data and the processor pipeline are all handled outside this block.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `bad_vaddr` is 0. Every entry in both arrays reads back as all zero: not valid, writable, use and dirty clear.
- R2: A request sampled at a clock edge produces its response, with `rsp_valid`=1, at that same edge. A cycle with no request leaves `rsp_valid` at 0 after the next edge.
- R3: The virtual page number is `req_addr[31:7]` and the offset is `req_addr[6:0]`. A successful response gives `rsp_paddr` = {zeros, ppn, offset} with exception code 0.
- R4: In associative mode (`use_tlb`=1), all four entries are compared against the page number. When several valid entries match, the lowest index wins. If no valid entry matches, the code is 2 (page fault).
- R5: In linear mode (`use_tlb`=0), a page number at or above `pt_size`, or at or above 8, gives code 5. Inside that bound, an entry that is not valid gives code 2.
- R6: Size code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. A 2-byte access with `req_addr[0]`=1, a 4-byte access with `req_addr[1:0]`≠0, and size code 3 all give code 5 (address error).
- R7: A write to an entry marked read-only gives code 3. A read of such an entry succeeds.
- R8: When the selected ppn is 32 or more, the code is 4 (bus error).
- R9: Only the highest-priority fault is reported. The order is: misalignment, then range or no-match, then read-only, then bus error.
- R10: On any exception, `rsp_paddr` is 0 and `bad_vaddr` takes the request address. A successful response leaves `bad_vaddr` unchanged.
- R11: A successful lookup sets the use bit of the entry it used. A successful write also sets that entry's dirty bit. A faulting lookup changes neither bit.
- R12: `wr_en` stores all fields of the entry chosen by `wr_tlb`/`wr_idx`, and this write takes precedence over a use/dirty update to the same entry in that cycle. The read port shows the entry chosen by `rd_tlb`/`rd_idx` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_tlb | input | 1 | 1 = associative entries, 0 = linear page table |
| pt_size | input | 4 | Number of page-table entries in use (linear mode bound) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Virtual byte address |
| req_size | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3 reserved |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_exc | output | 3 | Exception code: 0 none, 2 page fault, 3 read-only, 4 bus error, 5 address error |
| rsp_paddr | output | 32 | Physical address, 0 on exception |
| bad_vaddr | output | 32 | Last faulting virtual address |
| wr_en | input | 1 | Entry write strobe |
| wr_tlb | input | 1 | 1 = write associative entry, 0 = page-table entry |
| wr_idx | input | 3 | Entry index for writing |
| wr_vpn | input | 25 | Virtual page number (associative entries only) |
| wr_ppn | input | 8 | Physical page number |
| wr_valid | input | 1 | Entry valid |
| wr_ro | input | 1 | Entry read-only |
| wr_use | input | 1 | Use bit value to store |
| wr_dirty | input | 1 | Dirty bit value to store |
| rd_tlb | input | 1 | 1 = read associative entry, 0 = page-table entry |
| rd_idx | input | 3 | Entry index for reading |
| rd_vpn | output | 25 | Entry virtual page number (0 for page table) |
| rd_ppn | output | 8 | Entry physical page number |
| rd_valid | output | 1 | Entry valid bit |
| rd_ro | output | 1 | Entry read-only bit |
| rd_use | output | 1 | Entry use bit |
| rd_dirty | output | 1 | Entry dirty bit |

## Verification
The translation result, the exception code and the bad-address capture all appear at the clock edge that samples the request, so they are due one cycle after the request. The bench presents each request at a falling edge and reads the response shortly after the next rising edge. The use and dirty updates land at that same edge, but they are observed only afterwards, through the combinational read port, with the request already withdrawn. An entry write is also checked on the cycle after it, through the read port. That includes the case where an entry write and a lookup of the same entry fall in one cycle.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int AW         = 32,
  parameter int OFF_W      = 7,
  parameter int TLB_N      = 4,
  parameter int PT_N       = 8,
  parameter int PPN_W      = 8,
  parameter int PHYS_PAGES = 32,
  localparam int VPN_W = AW - OFF_W,
  localparam int TI_W  = $clog2(TLB_N),
  localparam int PI_W  = $clog2(PT_N),
  localparam int IDX_W = (TI_W > PI_W) ? TI_W : PI_W,
  localparam int SZ_W  = $clog2(PT_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_tlb,
  input  logic [SZ_W-1:0]  pt_size,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [2:0]       rsp_exc,
  output logic [AW-1:0]    rsp_paddr,
  output logic [AW-1:0]    bad_vaddr,
  input  logic             wr_en,
  input  logic             wr_tlb,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_valid,
  input  logic             wr_ro,
  input  logic             wr_use,
  input  logic             wr_dirty,
  input  logic             rd_tlb,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_valid,
  output logic             rd_ro,
  output logic             rd_use,
  output logic             rd_dirty
);
  localparam logic [2:0] EXC_NONE = 3'd0, EXC_PF = 3'd2, EXC_RO = 3'd3,
                         EXC_BUS = 3'd4, EXC_ADDR = 3'd5;

  logic [VPN_W-1:0] t_vpn [TLB_N];
  logic [PPN_W-1:0] t_ppn [TLB_N];
  logic [TLB_N-1:0] t_v, t_ro, t_u, t_d;
  logic [PPN_W-1:0] p_ppn [PT_N];
  logic [PT_N-1:0]  p_v, p_ro, p_u, p_d;

  wire [VPN_W-1:0] vpn  = req_addr[AW-1:OFF_W];
  wire [PI_W-1:0]  pidx = vpn[PI_W-1:0];

  wire misalign = (req_size == 2'd1 && req_addr[0]) ||
                  (req_size == 2'd2 && req_addr[1:0] != 2'b00) ||
                  (req_size == 2'd3);
  wire in_range = (vpn < VPN_W'(pt_size)) && (vpn < VPN_W'(PT_N));

  logic            hit;
  logic [TI_W-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = TLB_N - 1; i >= 0; i--)
      if (t_v[i] && t_vpn[i] == vpn) begin
        hit  = 1'b1;
        hidx = TI_W'(i);
      end
  end

  wire             found   = use_tlb ? hit : p_v[pidx];
  wire             sel_ro  = use_tlb ? t_ro[hidx] : p_ro[pidx];
  wire [PPN_W-1:0] sel_ppn = use_tlb ? t_ppn[hidx] : p_ppn[pidx];

  logic [2:0] exc;
  always_comb begin
    if (misalign)                        exc = EXC_ADDR;
    else if (!use_tlb && !in_range)      exc = EXC_ADDR;
    else if (!found)                     exc = EXC_PF;
    else if (req_write && sel_ro)        exc = EXC_RO;
    else if (sel_ppn >= PPN_W'(PHYS_PAGES)) exc = EXC_BUS;
    else                                 exc = EXC_NONE;
  end

  wire [AW-1:0] paddr = {{(AW-PPN_W-OFF_W){1'b0}}, sel_ppn, req_addr[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_exc   <= EXC_NONE;
      rsp_paddr <= '0;
      bad_vaddr <= '0;
      t_v <= '0; t_ro <= '0; t_u <= '0; t_d <= '0;
      p_v <= '0; p_ro <= '0; p_u <= '0; p_d <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        t_vpn[i] <= '0;
        t_ppn[i] <= '0;
      end
      for (int i = 0; i < PT_N; i++) p_ppn[i] <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_exc   <= exc;
        rsp_paddr <= (exc == EXC_NONE) ? paddr : '0;
        if (exc != EXC_NONE) bad_vaddr <= req_addr;
        else if (use_tlb) begin
          t_u[hidx] <= 1'b1;
          if (req_write) t_d[hidx] <= 1'b1;
        end else begin
          p_u[pidx] <= 1'b1;
          if (req_write) p_d[pidx] <= 1'b1;
        end
      end
      if (wr_en) begin
        if (wr_tlb) begin
          t_vpn[wr_idx[TI_W-1:0]] <= wr_vpn;
          t_ppn[wr_idx[TI_W-1:0]] <= wr_ppn;
          t_v[wr_idx[TI_W-1:0]]   <= wr_valid;
          t_ro[wr_idx[TI_W-1:0]]  <= wr_ro;
          t_u[wr_idx[TI_W-1:0]]   <= wr_use;
          t_d[wr_idx[TI_W-1:0]]   <= wr_dirty;
        end else begin
          p_ppn[wr_idx[PI_W-1:0]] <= wr_ppn;
          p_v[wr_idx[PI_W-1:0]]   <= wr_valid;
          p_ro[wr_idx[PI_W-1:0]]  <= wr_ro;
          p_u[wr_idx[PI_W-1:0]]   <= wr_use;
          p_d[wr_idx[PI_W-1:0]]   <= wr_dirty;
        end
      end
    end
  end

  wire [TI_W-1:0] rti = rd_idx[TI_W-1:0];
  wire [PI_W-1:0] rpi = rd_idx[PI_W-1:0];
  assign rd_vpn   = rd_tlb ? t_vpn[rti] : '0;
  assign rd_ppn   = rd_tlb ? t_ppn[rti] : p_ppn[rpi];
  assign rd_valid = rd_tlb ? t_v[rti]   : p_v[rpi];
  assign rd_ro    = rd_tlb ? t_ro[rti]  : p_ro[rpi];
  assign rd_use   = rd_tlb ? t_u[rti]   : p_u[rpi];
  assign rd_dirty = rd_tlb ? t_d[rti]   : p_d[rpi];
endmodule

module tlb_xlate_chk #(
  parameter int AW         = 32,
  parameter int OFF_W      = 7,
  parameter int PHYS_PAGES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic [2:0]    rsp_exc,
  input logic [AW-1:0] rsp_paddr,
  input logic [AW-1:0] bad_vaddr
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_exc != 3'd0 || rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))); // R3
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> rsp_exc == 3'd5); // R6
  AST_INSIDE_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 3'd0) |-> rsp_paddr < (AW'(PHYS_PAGES) << OFF_W)); // R8
  AST_BAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_exc == 3'd0 || bad_vaddr == $past(req_addr))); // R10
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc != 3'd0) |-> rsp_paddr == '0); // R10
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_exc == 3'd0 || (rsp_exc >= 3'd2 && rsp_exc <= 3'd5))); // R9
endmodule

bind tlb_xlate tlb_xlate_chk #(.AW(AW), .OFF_W(OFF_W), .PHYS_PAGES(PHYS_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc),
  .rsp_paddr(rsp_paddr), .bad_vaddr(bad_vaddr)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        tlb;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        wr;
    logic [2:0]  exc;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0805, 2'd0, 1'b0, 3'd0, 32'h0000_0185}, // R3 R4 hit entry 0
    '{1'b1, 32'h0000_1004, 2'd2, 1'b0, 3'd0, 32'h0000_0384}, // R7 read of RO page
    '{1'b1, 32'h0000_1004, 2'd2, 1'b1, 3'd3, 32'h0},         // R7 write to RO page
    '{1'b1, 32'h0000_1802, 2'd1, 1'b0, 3'd4, 32'h0},         // R8 ppn 40
    '{1'b1, 32'h0000_2000, 2'd0, 1'b0, 3'd2, 32'h0},         // R4 invalid entry
    '{1'b1, 32'h0000_1001, 2'd2, 1'b1, 3'd5, 32'h0},         // R9 misalign over RO
    '{1'b1, 32'h0000_2003, 2'd1, 1'b0, 3'd5, 32'h0},         // R9 misalign over miss
    '{1'b1, 32'h0000_1800, 2'd2, 1'b1, 3'd4, 32'h0},         // R8 write, bus error
    '{1'b1, 32'h0000_0800, 2'd3, 1'b0, 3'd5, 32'h0},         // R6 reserved size
    '{1'b0, 32'h0000_007c, 2'd2, 1'b1, 3'd0, 32'h0000_00fc}, // R5 linear write
    '{1'b0, 32'h0000_0090, 2'd1, 1'b1, 3'd3, 32'h0},         // R7 linear RO
    '{1'b0, 32'h0000_0100, 2'd0, 1'b0, 3'd4, 32'h0},         // R8 linear ppn 33
    '{1'b0, 32'h0000_0180, 2'd0, 1'b0, 3'd2, 32'h0},         // R5 invalid entry
    '{1'b0, 32'h0000_027f, 2'd0, 1'b0, 3'd0, 32'h0000_0fff}, // R3 last page, last byte
    '{1'b0, 32'h0000_0300, 2'd0, 1'b0, 3'd5, 32'h0},         // R5 past pt_size
    '{1'b0, 32'h0000_0805, 2'd0, 1'b0, 3'd5, 32'h0},         // R5 past table depth
    '{1'b0, 32'h0000_0282, 2'd1, 1'b0, 3'd2, 32'h0}          // R5 in range, invalid
  };

  logic clk = 0, rst_n = 0;
  logic use_tlb = 0;
  logic [3:0] pt_size = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic rsp_valid;
  logic [2:0] rsp_exc;
  logic [31:0] rsp_paddr, bad_vaddr;
  logic wr_en = 0, wr_tlb = 0, wr_valid = 0, wr_ro = 0, wr_use = 0, wr_dirty = 0;
  logic [2:0] wr_idx = 0;
  logic [24:0] wr_vpn = 0;
  logic [7:0] wr_ppn = 0;
  logic rd_tlb = 0;
  logic [2:0] rd_idx = 0;
  logic [24:0] rd_vpn;
  logic [7:0] rd_ppn;
  logic rd_valid, rd_ro, rd_use, rd_dirty;

  int total = 0, bad = 0;
  logic [31:0] exp_bad = 0;
  bit finished = 0;

  tlb_xlate uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ent(input logic t, input logic [2:0] i, input logic [24:0] v,
                         input logic [7:0] p, input logic val, input logic ro);
    @(negedge clk);
    wr_en = 1; wr_tlb = t; wr_idx = i; wr_vpn = v; wr_ppn = p;
    wr_valid = val; wr_ro = ro; wr_use = 0; wr_dirty = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic t, input logic [31:0] a, input logic [1:0] s, input logic w);
    @(negedge clk);
    use_tlb = t; req_valid = 1; req_addr = a; req_size = s; req_write = w;
    @(posedge clk);
    #1;
    req_valid = 0;
  endtask

  task automatic peek(input logic t, input logic [2:0] i, input string req,
                      input logic eu, input logic ed);
    rd_tlb = t; rd_idx = i;
    #1;
    check({req, " use"}, 32'(rd_use), 32'(eu));
    check({req, " dirty"}, 32'(rd_dirty), 32'(ed));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 bad_vaddr", bad_vaddr, 0);
    rd_tlb = 1; rd_idx = 0; #1;
    check("R1 tlb entry", {rd_valid, rd_ro, rd_use, rd_dirty, rd_ppn, 20'(rd_vpn)}, 0);
    rd_tlb = 0; rd_idx = 7; #1;
    check("R1 pt entry", {rd_valid, rd_ro, rd_use, rd_dirty, rd_ppn}, 0);
    rst_n = 1;
    pt_size = 6;

    set_ent(1, 0, 25'h10, 8'd3, 1, 0);
    set_ent(1, 1, 25'h20, 8'd7, 1, 1);
    set_ent(1, 2, 25'h30, 8'd40, 1, 0);
    set_ent(1, 3, 25'h40, 8'd9, 0, 0);
    set_ent(0, 0, 0, 8'd1, 1, 0);
    set_ent(0, 1, 0, 8'd2, 1, 1);
    set_ent(0, 2, 0, 8'd33, 1, 0);
    set_ent(0, 3, 0, 8'd5, 0, 0);
    set_ent(0, 4, 0, 8'd31, 1, 0);
    set_ent(0, 5, 0, 8'd6, 0, 0);

    rd_tlb = 1; rd_idx = 1; #1;
    check("R12 written ppn", 32'(rd_ppn), 7);
    check("R12 written vpn", 32'(rd_vpn), 32'h20);
    check("R12 written ro", 32'(rd_ro), 1);

    for (int k = 0; k < NV; k++) begin
      lookup(VECS[k].tlb, VECS[k].addr, VECS[k].sz, VECS[k].wr);
      if (VECS[k].exc != 0) exp_bad = VECS[k].addr;
      check($sformatf("R2 vec%0d valid", k), 32'(rsp_valid), 1);
      check($sformatf("R9 vec%0d exc", k), 32'(rsp_exc), 32'(VECS[k].exc));
      check($sformatf("R3 vec%0d paddr", k), rsp_paddr, VECS[k].pa);
      check($sformatf("R10 vec%0d bad_vaddr", k), bad_vaddr, exp_bad);
    end

    @(posedge clk); #1;
    check("R2 idle no rsp", 32'(rsp_valid), 0);

    peek(1, 0, "R11 tlb0", 1, 0);
    peek(1, 1, "R11 tlb1", 1, 0);
    peek(1, 2, "R11 tlb2", 0, 0);
    peek(0, 0, "R11 pt0", 1, 1);
    peek(0, 1, "R11 pt1", 0, 0);
    peek(0, 2, "R11 pt2", 0, 0);
    peek(0, 4, "R11 pt4", 1, 0);

    lookup(1, 32'h0000_0806, 2'd1, 1'b1);
    check("R11 write ok", 32'(rsp_exc), 0);
    check("R10 bad held", bad_vaddr, exp_bad);
    peek(1, 0, "R11 tlb0 after write", 1, 1);

    set_ent(1, 3, 25'h10, 8'd5, 1, 0);
    lookup(1, 32'h0000_0805, 2'd0, 1'b0);
    check("R4 lowest index wins", rsp_paddr, 32'h0000_0185);
    peek(1, 3, "R4 higher dup untouched", 0, 0);

    @(negedge clk);
    use_tlb = 1; req_valid = 1; req_addr = 32'h0000_0804; req_size = 2'd2; req_write = 1;
    wr_en = 1; wr_tlb = 1; wr_idx = 0; wr_vpn = 25'h10; wr_ppn = 8'd3;
    wr_valid = 1; wr_ro = 0; wr_use = 0; wr_dirty = 0;
    @(posedge clk); #1;
    req_valid = 0; wr_en = 0;
    check("R12 same-cycle exc", 32'(rsp_exc), 0);
    peek(1, 0, "R12 write wins", 0, 0);

    lookup(1, 32'h0000_1004, 2'd0, 1'b1);
    check("R7 byte write RO", 32'(rsp_exc), 3);
    check("R10 bad captured", bad_vaddr, 32'h0000_1004);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule